// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block holds a small set of pending operations in front of one functional unit and decides on its own when each can start. Every entry is named by a fixed tag of its own. Any later operation that needs the entry's result waits on that tag, so two entries in front of one unit appear to the rest of the machine as two separate producers. Each of the two operand slots in an entry holds either a finished value or the tag of the producer it is waiting for.

All producers broadcast completed results on a shared result bus as a tag and data pair. Every waiting slot compares its tag with the bus on every cycle and takes the data when they match. No central table tracks readiness. When both operands of an entry are present and the unit signals that it is free, the station sends the operation to the unit with the entry's tag attached. The entry stays allocated to that operation until the unit's result is broadcast under the same tag. After that broadcast the entry accepts a new issue.

Top module: `rs_station`

## Requirements
- R1: After reset every entry is free, `iss_ready` is high, `disp_valid` is low and `ent_busy` is all zero.
- R2: An issue is accepted when `iss_valid` and `iss_ready` are both high. It takes the lowest-numbered free entry. Entry k carries tag BASE_TAG+k (1 and 2 by default), and `iss_tag` reports the tag the next accepted issue will receive. When every entry is busy, `iss_ready` is low and an issue is ignored, so it never reaches the dispatch port.
- R3: An operand tag of 0 means the value field is the operand. A non-zero tag means the slot waits for the producer with that tag.
- R4: A waiting slot whose tag equals `cdb_tag` while `cdb_valid` is high stores `cdb_data` and counts as ready from the next cycle.
- R5: If a non-zero issued operand tag equals the tag broadcast in the issue cycle, the slot stores the broadcast data at issue and is ready on the next cycle.
- R6: An entry dispatches when it is busy, not yet dispatched, has both operands ready, and `fu_ready` is high. The dispatch outputs present its opcode, operand values and own tag in that same cycle. Each issued operation dispatches exactly once.
- R7: When several entries can dispatch, the one issued earliest goes first, whatever its entry number.
- R8: An entry becomes free in the cycle after `cdb_valid` is high with `cdb_tag` equal to the entry's own tag. A broadcast carrying tag 0, or a tag that no waiting slot holds, changes no operand and frees no entry.
- R9: While `fu_ready` is low, `disp_valid` is low and ready entries keep their operands until the unit is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | New operation offered for issue |
| iss_op | input | OP_W | Opcode of the offered operation |
| iss_a_tag | input | TAG_W | First operand producer tag, 0 when value is present |
| iss_a_val | input | DATA_W | First operand value |
| iss_b_tag | input | TAG_W | Second operand producer tag, 0 when value is present |
| iss_b_val | input | DATA_W | Second operand value |
| iss_ready | output | 1 | At least one entry is free |
| iss_tag | output | TAG_W | Tag the next accepted issue will carry |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcasting producer |
| cdb_data | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Functional unit can accept an operation |
| disp_valid | output | 1 | Operation sent to the unit this cycle |
| disp_op | output | OP_W | Opcode sent to the unit |
| disp_a | output | DATA_W | First operand sent to the unit |
| disp_b | output | DATA_W | Second operand sent to the unit |
| disp_tag | output | TAG_W | Tag the unit returns with its result |
| ent_busy | output | ENTRIES | Per-entry occupied flags |

## Verification
On every cycle the assertions check four things. A tag match in any slot, whether it happens at issue or while waiting, must leave that slot ready on the next cycle. At most one entry may be granted, and only one that is busy with both operands present. A dispatched entry must not be granted again, and an entry whose own tag is broadcast must be free on the next cycle. Some behaviours need sequences of stimulus that only the bench scenarios provide. One is oldest-first ordering when the older operation sits in the higher-numbered entry. Another is that an issue offered while the station is full never appears at the dispatch port. The bench also confirms that non-matching and tag-0 broadcasts leave waiting operations untouched, and it compares the actual data values captured from the bus.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_DATA_W   = 32;
  localparam int RS_TAG_W    = 3;
  localparam int RS_OP_W     = 4;
  localparam int RS_ENTRIES  = 2;
  localparam int RS_BASE_TAG = 1;
endpackage

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int DATA_W = rs_pkg::RS_DATA_W,
  parameter int TAG_W  = rs_pkg::RS_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic [DATA_W-1:0] val_o,
  output logic              rdy_o,
  output logic              hit_o
);
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;

  function automatic logic snoop_match(input logic bus_v,
                                       input logic [TAG_W-1:0] bus_tag,
                                       input logic [TAG_W-1:0] wait_tag);
    return bus_v && (wait_tag != '0) && (bus_tag == wait_tag);
  endfunction

  assign hit_o = load_i ? snoop_match(cdb_valid_i, cdb_tag_i, ld_tag_i)
                        : snoop_match(cdb_valid_i, cdb_tag_i, tag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= '0;
    end else if (hit_o) begin
      tag_q <= '0;
      val_q <= cdb_data_i;
    end else if (load_i) begin
      tag_q <= ld_tag_i;
      val_q <= ld_val_i;
    end
  end

  assign val_o = val_q;
  assign rdy_o = (tag_q == '0);
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int ENTRIES = rs_pkg::RS_ENTRIES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] alloc_i,
  input  logic [ENTRIES-1:0] busy_i,
  input  logic [ENTRIES-1:0] req_i,
  output logic [ENTRIES-1:0] grant_o
);
  // older_q[j][i] set: entry j was issued before entry i
  logic [ENTRIES-1:0] older_q [ENTRIES];

  function automatic logic beaten(input int idx,
                                  input logic [ENTRIES-1:0] req,
                                  input logic [ENTRIES-1:0] col);
    logic b;
    b = 1'b0;
    for (int j = 0; j < ENTRIES; j++)
      if (j != idx && req[j] && col[j]) b = 1'b1;
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ENTRIES; r++) older_q[r] <= '0;
    end else begin
      for (int n = 0; n < ENTRIES; n++) begin
        if (alloc_i[n]) begin
          for (int j = 0; j < ENTRIES; j++) begin
            if (j != n) older_q[j][n] <= busy_i[j];
            older_q[n][j] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [ENTRIES-1:0] col;
      for (int j = 0; j < ENTRIES; j++) col[j] = older_q[j][i];
      grant_o[i] = req_i[i] && !beaten(i, req_i, col);
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int DATA_W   = rs_pkg::RS_DATA_W,
  parameter int TAG_W    = rs_pkg::RS_TAG_W,
  parameter int OP_W     = rs_pkg::RS_OP_W,
  parameter int ENTRIES  = rs_pkg::RS_ENTRIES,
  parameter int BASE_TAG = rs_pkg::RS_BASE_TAG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  input  logic [OP_W-1:0]    iss_op,
  input  logic [TAG_W-1:0]   iss_a_tag,
  input  logic [DATA_W-1:0]  iss_a_val,
  input  logic [TAG_W-1:0]   iss_b_tag,
  input  logic [DATA_W-1:0]  iss_b_val,
  output logic               iss_ready,
  output logic [TAG_W-1:0]   iss_tag,
  input  logic               cdb_valid,
  input  logic [TAG_W-1:0]   cdb_tag,
  input  logic [DATA_W-1:0]  cdb_data,
  input  logic               fu_ready,
  output logic               disp_valid,
  output logic [OP_W-1:0]    disp_op,
  output logic [DATA_W-1:0]  disp_a,
  output logic [DATA_W-1:0]  disp_b,
  output logic [TAG_W-1:0]   disp_tag,
  output logic [ENTRIES-1:0] ent_busy
);
  logic [ENTRIES-1:0] busy_q, sent_q;
  logic [ENTRIES-1:0] alloc_oh, ent_req, grant, disp_fire, free_hit;
  logic [ENTRIES-1:0] a_rdy, b_rdy, a_hit, b_hit;
  logic [DATA_W-1:0]  a_val [ENTRIES];
  logic [DATA_W-1:0]  b_val [ENTRIES];
  logic [OP_W-1:0]    op_q  [ENTRIES];
  logic               accept;

  function automatic logic [ENTRIES-1:0] pick_free(input logic [ENTRIES-1:0] busy);
    logic [ENTRIES-1:0] oh;
    logic found;
    oh = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!busy[i] && !found) begin
        oh[i] = 1'b1;
        found = 1'b1;
      end
    return oh;
  endfunction

  function automatic logic [TAG_W-1:0] entry_tag(input int idx);
    return TAG_W'(BASE_TAG + idx);
  endfunction

  function automatic logic [TAG_W-1:0] free_tag(input logic [ENTRIES-1:0] busy);
    logic [TAG_W-1:0] t;
    t = entry_tag(0);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!busy[i]) t = entry_tag(i);
    return t;
  endfunction

  assign iss_ready = ~&busy_q;
  assign iss_tag   = free_tag(busy_q);
  assign accept    = iss_valid && iss_ready;
  assign alloc_oh  = accept ? pick_free(busy_q) : '0;
  assign ent_busy  = busy_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(BASE_TAG + e);

    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot_a (
      .clk(clk), .rst_n(rst_n), .load_i(alloc_oh[e]),
      .ld_tag_i(iss_a_tag), .ld_val_i(iss_a_val),
      .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
      .val_o(a_val[e]), .rdy_o(a_rdy[e]), .hit_o(a_hit[e]));

    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot_b (
      .clk(clk), .rst_n(rst_n), .load_i(alloc_oh[e]),
      .ld_tag_i(iss_b_tag), .ld_val_i(iss_b_val),
      .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
      .val_o(b_val[e]), .rdy_o(b_rdy[e]), .hit_o(b_hit[e]));

    assign free_hit[e]  = busy_q[e] && cdb_valid && (cdb_tag == OWN_TAG);
    assign ent_req[e]   = busy_q[e] && !sent_q[e] && a_rdy[e] && b_rdy[e];
    assign disp_fire[e] = grant[e] && fu_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[e] <= 1'b0;
        sent_q[e] <= 1'b0;
        op_q[e]   <= '0;
      end else if (alloc_oh[e]) begin
        busy_q[e] <= 1'b1;
        sent_q[e] <= 1'b0;
        op_q[e]   <= iss_op;
      end else begin
        if (free_hit[e]) busy_q[e] <= 1'b0;
        if (disp_fire[e]) sent_q[e] <= 1'b1;
      end
    end
  end

  rs_age_pick #(.ENTRIES(ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc_oh), .busy_i(busy_q),
    .req_i(ent_req), .grant_o(grant));

  assign disp_valid = fu_ready && (|grant);

  always_comb begin
    disp_op  = '0;
    disp_a   = '0;
    disp_b   = '0;
    disp_tag = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        disp_op  = disp_op  | op_q[i];
        disp_a   = disp_a   | a_val[i];
        disp_b   = disp_b   | b_val[i];
        disp_tag = disp_tag | entry_tag(i);
      end
    end
  end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
  parameter int ENTRIES = rs_pkg::RS_ENTRIES
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_ready,
  input logic               fu_ready,
  input logic               disp_valid,
  input logic [ENTRIES-1:0] ent_busy,
  input logic [ENTRIES-1:0] alloc_oh,
  input logic [ENTRIES-1:0] grant,
  input logic [ENTRIES-1:0] disp_fire,
  input logic [ENTRIES-1:0] a_hit,
  input logic [ENTRIES-1:0] b_hit,
  input logic [ENTRIES-1:0] a_rdy,
  input logic [ENTRIES-1:0] b_rdy,
  input logic [ENTRIES-1:0] free_hit
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7
  AST_DISP_NEEDS_FU: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> fu_ready); // R9
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_busy) |-> !iss_ready); // R2

  for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
    AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_oh[e] |=> ent_busy[e]); // R2
    AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
      a_hit[e] |=> a_rdy[e]); // R4
    AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
      b_hit[e] |=> b_rdy[e]); // R4
    AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_oh[e] && a_hit[e]) |=> a_rdy[e]); // R5
    AST_GRANT_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      grant[e] |-> (ent_busy[e] && a_rdy[e] && b_rdy[e])); // R6
    AST_DISPATCH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      disp_fire[e] |=> !grant[e]); // R6
    AST_RESULT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      free_hit[e] |=> !ent_busy[e]); // R8
  end
endmodule

bind rs_station rs_station_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_ready(iss_ready), .fu_ready(fu_ready),
  .disp_valid(disp_valid), .ent_busy(ent_busy), .alloc_oh(alloc_oh),
  .grant(grant), .disp_fire(disp_fire), .a_hit(a_hit), .b_hit(b_hit),
  .a_rdy(a_rdy), .b_rdy(b_rdy), .free_hit(free_hit));

// File: tb/rs_station_tb.sv
module rs_station_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, cdb_valid, fu_ready;
  logic [3:0]  iss_op;
  logic [2:0]  iss_a_tag, iss_b_tag, cdb_tag;
  logic [31:0] iss_a_val, iss_b_val, cdb_data;
  logic        iss_ready, disp_valid;
  logic [2:0]  iss_tag, disp_tag;
  logic [3:0]  disp_op;
  logic [31:0] disp_a, disp_b;
  logic [1:0]  ent_busy;

  rs_station u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural reference
  bit          m_busy [NE];
  bit          m_sent [NE];
  logic [3:0]  m_op   [NE];
  logic [2:0]  m_at   [NE];
  logic [2:0]  m_bt   [NE];
  logic [31:0] m_av   [NE];
  logic [31:0] m_bv   [NE];
  int          m_seq  [NE];
  int          seq_ctr = 0;
  int          m_sel;
  bit          m_disp;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic drv(input bit iv, input logic [3:0] op, input logic [2:0] at,
                     input logic [31:0] av, input logic [2:0] bt, input logic [31:0] bv,
                     input bit cv, input logic [2:0] ct, input logic [31:0] cd, input bit fr);
    iss_valid = iv; iss_op = op; iss_a_tag = at; iss_a_val = av;
    iss_b_tag = bt; iss_b_val = bv; cdb_valid = cv; cdb_tag = ct; cdb_data = cd;
    fu_ready = fr;
  endtask

  task automatic idle(input bit fr);
    drv(0, 0, 0, 0, 0, 0, 0, 0, 0, fr);
  endtask

  task automatic bcast(input logic [2:0] t, input logic [31:0] d, input bit fr);
    drv(0, 0, 0, 0, 0, 0, 1, t, d, fr);
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NE; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  task automatic tick();
    int k;
    logic [1:0] eb;
    #1;
    m_sel = -1;
    for (int i = 0; i < NE; i++)
      if (m_busy[i] && !m_sent[i] && m_at[i] == 0 && m_bt[i] == 0 &&
          (m_sel < 0 || m_seq[i] < m_seq[m_sel])) m_sel = i;
    k = lowest_free();
    chk(iss_ready == (k >= 0), "R2 iss_ready", iss_ready, k >= 0);
    if (k >= 0) chk(iss_tag == 3'(k + 1), "R2 iss_tag", iss_tag, k + 1);
    m_disp = fu_ready && m_sel >= 0;
    chk(disp_valid == m_disp, "R6 disp_valid", disp_valid, m_disp);
    if (m_disp) begin
      chk(disp_op == m_op[m_sel], "R6 disp_op", disp_op, m_op[m_sel]);
      chk(disp_a == m_av[m_sel], "R6 disp_a", disp_a, m_av[m_sel]);
      chk(disp_b == m_bv[m_sel], "R6 disp_b", disp_b, m_bv[m_sel]);
      chk(disp_tag == 3'(m_sel + 1), "R7 disp_tag", disp_tag, m_sel + 1);
    end
    for (int i = 0; i < NE; i++) eb[i] = m_busy[i];
    chk(ent_busy == eb, "R8 ent_busy", ent_busy, eb);
    @(posedge clk);
    if (m_disp) m_sent[m_sel] = 1;
    for (int i = 0; i < NE; i++) begin
      if (m_busy[i] && cdb_valid && cdb_tag != 0 && m_at[i] == cdb_tag) begin
        m_at[i] = 0; m_av[i] = cdb_data;
      end
      if (m_busy[i] && cdb_valid && cdb_tag != 0 && m_bt[i] == cdb_tag) begin
        m_bt[i] = 0; m_bv[i] = cdb_data;
      end
      if (m_busy[i] && cdb_valid && cdb_tag == 3'(i + 1)) m_busy[i] = 0;
    end
    if (iss_valid && k >= 0) begin
      m_busy[k] = 1; m_sent[k] = 0; m_op[k] = iss_op; m_seq[k] = seq_ctr++;
      m_at[k] = iss_a_tag; m_av[k] = iss_a_val;
      m_bt[k] = iss_b_tag; m_bv[k] = iss_b_val;
      if (cdb_valid && iss_a_tag != 0 && iss_a_tag == cdb_tag) begin
        m_at[k] = 0; m_av[k] = cdb_data;
      end
      if (cdb_valid && iss_b_tag != 0 && iss_b_tag == cdb_tag) begin
        m_bt[k] = 0; m_bv[k] = cdb_data;
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [2:0] rtag();
    return ($urandom % 2 == 0) ? 3'd0 : 3'($urandom % 8);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin m_busy[i] = 0; m_sent[i] = 0; end
    idle(1);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(iss_ready == 1, "R1 iss_ready after reset", iss_ready, 1);
    chk(disp_valid == 0, "R1 disp_valid after reset", disp_valid, 0);
    chk(ent_busy == 0, "R1 ent_busy after reset", ent_busy, 0);

    // R3: both operands given as values
    drv(1, 4'd3, 0, 32'h11, 0, 32'h22, 0, 0, 0, 1); tick();
    idle(1); #1;
    chk(disp_valid && disp_a == 32'h11 && disp_b == 32'h22, "R3 value operands dispatch", disp_a, 32'h11);
    tick();
    idle(1); #1;
    chk(disp_valid == 0, "R6 no second dispatch", disp_valid, 0);
    tick();
    bcast(3'd1, 32'h5, 1); tick();

    // R4: wait on tag 5, capture from bus
    drv(1, 4'd5, 3'd5, 0, 0, 32'h33, 0, 0, 0, 1); tick();
    idle(1); #1;
    chk(disp_valid == 0, "R4 waits for producer", disp_valid, 0);
    tick();
    bcast(3'd5, 32'hAA, 1); tick();
    idle(1); #1;
    chk(disp_valid && disp_a == 32'hAA, "R4 captured broadcast", disp_a, 32'hAA);
    tick();
    bcast(3'd1, 32'h0, 1); tick();

    // R5: bypass in the issue cycle
    drv(1, 4'd6, 3'd6, 0, 0, 32'h44, 1, 3'd6, 32'hBB, 1); tick();
    idle(1); #1;
    chk(disp_valid && disp_a == 32'hBB, "R5 issue-cycle bypass", disp_a, 32'hBB);
    tick();
    bcast(3'd1, 32'h0, 1); tick();

    // R8: non-matching and tag-0 broadcasts change nothing
    drv(1, 4'd2, 3'd4, 0, 0, 32'h55, 0, 0, 0, 1); tick();
    bcast(3'd3, 32'hDEAD, 1); tick();
    bcast(3'd0, 32'hBEEF, 1); #1;
    chk(disp_valid == 0, "R8 foreign broadcasts ignored", disp_valid, 0);
    chk(ent_busy == 2'b01, "R8 entry kept", ent_busy, 2'b01);
    tick();
    bcast(3'd4, 32'h77, 1); tick();
    idle(1); #1;
    chk(disp_a == 32'h77, "R8 later matching broadcast captured", disp_a, 32'h77);
    tick();
    bcast(3'd1, 32'h0, 1); tick();

    // R2: full station ignores issue
    drv(1, 4'd8, 3'd5, 0, 0, 32'h1, 0, 0, 0, 0); tick();
    drv(1, 4'd9, 3'd6, 0, 0, 32'h2, 0, 0, 0, 0); tick();
    drv(1, 4'd7, 0, 32'h99, 0, 32'h98, 0, 0, 0, 0); #1;
    chk(iss_ready == 0, "R2 full station not ready", iss_ready, 0);
    tick();
    bcast(3'd5, 32'h10, 0); tick();
    bcast(3'd6, 32'h20, 0); tick();
    idle(1); tick(); idle(1); tick();
    idle(1); #1;
    chk(disp_valid == 0, "R2 ignored issue never dispatches", disp_valid, 0);
    tick();
    bcast(3'd1, 0, 1); tick(); bcast(3'd2, 0, 1); tick();

    // R7: older entry sits in higher index
    drv(1, 4'd1, 0, 32'hA, 0, 32'hB, 0, 0, 0, 1); tick();
    drv(1, 4'd2, 3'd6, 0, 0, 32'hC, 0, 0, 0, 1); tick();
    bcast(3'd1, 0, 0); tick();
    drv(1, 4'd3, 3'd7, 0, 0, 32'hD, 0, 0, 0, 0); tick();
    bcast(3'd6, 32'h66, 0); tick();
    bcast(3'd7, 32'h67, 0); tick();
    idle(0); #1;
    chk(disp_valid == 0, "R9 held while unit busy", disp_valid, 0);
    tick();
    idle(1); #1;
    chk(disp_valid && disp_tag == 3'd2, "R7 oldest first", disp_tag, 2);
    tick();
    idle(1); #1;
    chk(disp_valid && disp_tag == 3'd1 && disp_a == 32'h67, "R7 younger next", disp_tag, 1);
    tick();
    bcast(3'd1, 0, 1); tick(); bcast(3'd2, 0, 1); tick();

    // mixed traffic compared against the reference every cycle
    for (int n = 0; n < 600; n++) begin
      drv($urandom % 2 == 0, 4'($urandom), rtag(), $urandom, rtag(), $urandom,
          $urandom % 2 == 0, 3'($urandom % 8), $urandom, $urandom % 4 != 0);
      tick();
    end
    finish_run();
  end
endmodule